// File: doc/BRIEF.md
# USB Bus Reset and PS/2 Activity Detector

This block watches the bus lines of a low-speed peripheral and tells the rest of the chip when a long bus condition has occurred. A free-running timebase divides the 6 MHz block clock into a fast tick every 128 µs (768 clocks) and a slow tick every 1.024 ms (eight fast ticks). Each tick can raise its own periodic timer interrupt, gated by a dedicated enable input.

A mode input picks which bus condition is watched. In USB mode the condition is a single-ended zero: both data lines low. In PS/2 mode it is the PS/2 data line held low. The condition is sampled only on fast ticks. Two consecutive samples that show it qualify an event, so the real duration needed lies between 128 µs and 256 µs. While a qualified event lasts, the device-address clear output is held high.

The bus interrupt is timed by mode. In PS/2 mode it fires as soon as the event qualifies. In USB mode it fires when the single-ended zero is seen to have ended, which can be up to one tick after the lines recover.

Top module: `busrst_ps2_detect`

## Requirements
- R1: `irq_fast` is a one-cycle pulse every CYC_PER_TICK clocks while `en_fast` is 1; it stays 0 while `en_fast` is 0.
- R2: `irq_slow` is a one-cycle pulse every TICKS_PER_SLOW fast periods while `en_slow` is 1. It pulses in the same cycle as a fast-tick pulse, and it stays 0 while `en_slow` is 0.
- R3: The bus condition is sampled only at fast ticks. QUAL_TICKS (default 2) consecutive samples showing it qualify an event. A sample without the condition restarts the count, and a change that falls wholly between two ticks has no effect.
- R4: In PS/2 mode (`usb_mode`=0) `irq_bus` pulses for one cycle right after the qualifying tick, once per event. Nothing fires when the line is released.
- R5: In USB mode (`usb_mode`=1) no interrupt fires when an event qualifies. `irq_bus` pulses for one cycle right after the first tick that samples the single-ended zero gone.
- R6: `addr_clear` goes high right after the qualifying tick. It stays high until right after the first tick that samples the condition absent.
- R7: The condition in USB mode is `dp`=0 and `dm`=0, and `ps2_data` is ignored; one data line low alone is not a condition. In PS/2 mode the condition is `ps2_data`=0, and `dp`/`dm` are ignored.
- R8: While `rst_n` is low, all outputs are 0, and a reset in the middle of an event clears `addr_clear`.
- R9: A bus interrupt and a timer interrupt that fall in the same cycle both appear, each on its own output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 6 MHz block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| usb_mode | input | 1 | 1: watch for single-ended zero, 0: watch PS/2 data low |
| dp | input | 1 | USB D+ line level |
| dm | input | 1 | USB D- line level |
| ps2_data | input | 1 | PS/2 data line level |
| en_fast | input | 1 | Enable for the 128 µs timer interrupt |
| en_slow | input | 1 | Enable for the 1.024 ms timer interrupt |
| irq_fast | output | 1 | 128 µs timer interrupt pulse |
| irq_slow | output | 1 | 1.024 ms timer interrupt pulse |
| irq_bus | output | 1 | Bus reset / PS/2 activity interrupt pulse |
| addr_clear | output | 1 | Holds the device address cleared during an event |

## Verification
Every bus decision is made on the same tick edge that produces the timer interrupts. Because of this, `irq_bus` always falls in the same cycle as an `irq_fast` pulse, and sometimes in the same cycle as an `irq_slow` pulse. The bench keeps the fast-timer enable on while it drives the bus vectors, so each bus interrupt coincides with a timer interrupt. It then checks that both outputs are high in that one sampled cycle and that neither masks the other.

// File: rtl/busrst_ps2_pkg.sv
package busrst_ps2_pkg;
  // Condition selected by the mode input
  typedef enum logic {
    WATCH_PS2 = 1'b0,
    WATCH_SE0 = 1'b1
  } watch_e;
endpackage

// File: rtl/busrst_rst_sync.sv
module busrst_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/busrst_timebase.sv
module busrst_timebase #(
  parameter int CYC_PER_TICK   = 768,
  parameter int TICKS_PER_SLOW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_fast,
  input  logic en_slow,
  output logic tick_fast,
  output logic tick_slow,
  output logic irq_fast,
  output logic irq_slow
);
  localparam int PW = (CYC_PER_TICK > 1) ? $clog2(CYC_PER_TICK) : 1;
  localparam int SW = (TICKS_PER_SLOW > 1) ? $clog2(TICKS_PER_SLOW) : 1;
  localparam logic [PW-1:0] PRE_LAST  = PW'(CYC_PER_TICK - 1);
  localparam logic [SW-1:0] SLOW_LAST = SW'(TICKS_PER_SLOW - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [SW-1:0] slow_q, slow_d;
  logic          irq_fast_d, irq_slow_d;

  always_comb begin
    tick_fast  = (pre_q == PRE_LAST);
    tick_slow  = tick_fast && (slow_q == SLOW_LAST);
    pre_d      = tick_fast ? '0 : pre_q + 1'b1;
    slow_d     = slow_q;
    if (tick_fast) begin
      slow_d = (slow_q == SLOW_LAST) ? '0 : slow_q + 1'b1;
    end
    irq_fast_d = tick_fast && en_fast;
    irq_slow_d = tick_slow && en_slow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q    <= '0;
      slow_q   <= '0;
      irq_fast <= 1'b0;
      irq_slow <= 1'b0;
    end else begin
      pre_q    <= pre_d;
      slow_q   <= slow_d;
      irq_fast <= irq_fast_d;
      irq_slow <= irq_slow_d;
    end
  end

  // R1
  fast_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fast |-> $past(en_fast));
  // R2
  slow_with_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_slow |-> $past(tick_fast));
endmodule

// File: rtl/busrst_qualifier.sv
module busrst_qualifier #(
  parameter int QUAL_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic usb_mode,
  input  logic cond,
  output logic evt,
  output logic irq
);
  import busrst_ps2_pkg::*;

  localparam int QW = $clog2(QUAL_TICKS + 1);
  localparam logic [QW-1:0] QMAX  = QW'(QUAL_TICKS);
  localparam logic [QW-1:0] QLAST = QW'(QUAL_TICKS - 1);

  watch_e        watch;
  logic [QW-1:0] qcnt_q, qcnt_d;
  logic          evt_d, irq_d;

  assign watch = watch_e'(usb_mode);

  always_comb begin
    qcnt_d = qcnt_q;
    evt_d  = evt;
    irq_d  = 1'b0;
    if (tick) begin
      if (cond) begin
        qcnt_d = (qcnt_q == QMAX) ? qcnt_q : qcnt_q + 1'b1;
        if (!evt && qcnt_q == QLAST) begin
          evt_d = 1'b1;
          irq_d = (watch == WATCH_PS2);
        end
      end else begin
        qcnt_d = '0;
        if (evt) begin
          evt_d = 1'b0;
          irq_d = (watch == WATCH_SE0);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt_q <= '0;
      evt    <= 1'b0;
      irq    <= 1'b0;
    end else begin
      qcnt_q <= qcnt_d;
      evt    <= evt_d;
      irq    <= irq_d;
    end
  end

  // R6
  evt_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(evt) || $fell(evt)) |-> $past(tick));
  // R4
  ps2_irq_at_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(evt) && !$past(usb_mode)) |-> irq);
  // R5
  usb_irq_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(usb_mode)) |-> (!evt && $past(evt)));
  // R4
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: rtl/busrst_ps2_detect.sv
module busrst_ps2_detect #(
  parameter int CYC_PER_TICK   = 768,
  parameter int TICKS_PER_SLOW = 8,
  parameter int QUAL_TICKS     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic usb_mode,
  input  logic dp,
  input  logic dm,
  input  logic ps2_data,
  input  logic en_fast,
  input  logic en_slow,
  output logic irq_fast,
  output logic irq_slow,
  output logic irq_bus,
  output logic addr_clear
);
  logic rst_sync_n;
  logic tick_fast, tick_slow;
  logic cond;

  busrst_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  busrst_timebase #(
    .CYC_PER_TICK   (CYC_PER_TICK),
    .TICKS_PER_SLOW (TICKS_PER_SLOW)
  ) u_tb (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en_fast   (en_fast),
    .en_slow   (en_slow),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow),
    .irq_fast  (irq_fast),
    .irq_slow  (irq_slow)
  );

  // R7: single-ended zero versus PS/2 data low
  assign cond = usb_mode ? (!dp && !dm) : !ps2_data;

  busrst_qualifier #(
    .QUAL_TICKS (QUAL_TICKS)
  ) u_qual (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (tick_fast),
    .usb_mode (usb_mode),
    .cond     (cond),
    .evt      (addr_clear),
    .irq      (irq_bus)
  );

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (!irq_bus && !addr_clear && !irq_fast && !irq_slow));
  // R9
  bus_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_bus |-> $past(tick_fast));
  // R2
  slow_implies_fast_tick_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tick_slow |-> tick_fast);
endmodule

// File: tb/busrst_ps2_detect_test.sv
module busrst_ps2_detect_test;
  localparam int CYC  = 16;
  localparam int SLOW = 8;

  logic clk = 1'b0;
  logic rst_n, usb_mode, dp, dm, ps2_data, en_fast, en_slow;
  logic irq_fast, irq_slow, irq_bus, addr_clear;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  busrst_ps2_detect #(.CYC_PER_TICK(CYC), .TICKS_PER_SLOW(SLOW), .QUAL_TICKS(2)) uut (
    .clk(clk), .rst_n(rst_n), .usb_mode(usb_mode), .dp(dp), .dm(dm),
    .ps2_data(ps2_data), .en_fast(en_fast), .en_slow(en_slow),
    .irq_fast(irq_fast), .irq_slow(irq_slow), .irq_bus(irq_bus),
    .addr_clear(addr_clear)
  );

  typedef struct packed {
    logic       usb;
    logic       vdp;
    logic       vdm;
    logic       vps2;
    logic [2:0] hold;
    logic [1:0] n_hold;
    logic       clr;
    logic [1:0] n_rel;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b1, 1'b1, 1'b0, 3'd2, 2'd1, 1'b1, 2'd0}, // R4 PS/2 low two ticks
    '{1'b0, 1'b1, 1'b1, 1'b0, 3'd1, 2'd0, 1'b0, 2'd0}, // R3 PS/2 low one tick
    '{1'b0, 1'b1, 1'b1, 1'b0, 3'd4, 2'd1, 1'b1, 2'd0}, // R4 long PS/2 low
    '{1'b1, 1'b0, 1'b0, 1'b1, 3'd2, 2'd0, 1'b1, 2'd1}, // R5 SE0 two ticks
    '{1'b1, 1'b0, 1'b0, 1'b1, 3'd1, 2'd0, 1'b0, 2'd0}, // R3 SE0 one tick
    '{1'b1, 1'b0, 1'b0, 1'b0, 3'd4, 2'd0, 1'b1, 2'd1}, // R5 long SE0
    '{1'b1, 1'b0, 1'b1, 1'b0, 3'd3, 2'd0, 1'b0, 2'd0}, // R7 one line low only
    '{1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 2'd0, 1'b0, 2'd0}  // R7 SE0 in PS/2 mode
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_lines();
    dp = 1'b1; dm = 1'b0; ps2_data = 1'b1;
  endtask

  // Waits until just after a fast-tick edge; counts irq_bus pulses and
  // the ones that coincide with irq_fast.
  task automatic wait_tick(inout int nbus, inout int ncoin);
    forever begin
      @(negedge clk);
      if (irq_bus) begin
        nbus++;
        if (irq_fast) ncoin++;
      end
      if (irq_fast) break;
    end
  endtask

  initial begin
    int nb, nc, last, gap;
    rst_n = 1'b0; usb_mode = 1'b0; en_fast = 1'b0; en_slow = 1'b0;
    idle_lines();
    repeat (4) @(negedge clk);
    // R8 reset state
    check(!irq_fast && !irq_slow && !irq_bus && !addr_clear, "R8 reset outputs",
          {irq_fast, irq_slow, irq_bus, addr_clear}, 0);
    rst_n = 1'b1;

    // R1 disabled fast timer stays silent
    nb = 0;
    repeat (5 * CYC) begin
      @(negedge clk);
      if (irq_fast || irq_slow) nb++;
    end
    check(nb == 0, "R1 timers disabled", nb, 0);

    // R1 fast period
    en_fast = 1'b1;
    nb = 0; nc = 0;
    wait_tick(nb, nc);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!irq_fast);
    check(gap == CYC, "R1 fast period", gap, CYC);

    // R2 slow period, coincident with fast
    en_slow = 1'b1;
    do @(negedge clk); while (!irq_slow);
    check(irq_fast == 1'b1, "R2 slow with fast", irq_fast, 1);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!irq_slow);
    check(gap == CYC * SLOW, "R2 slow period", gap, CYC * SLOW);
    en_slow = 1'b0;

    // Vector table
    foreach (VEC[i]) begin
      int hb, hc, rb, rc;
      hb = 0; hc = 0; rb = 0; rc = 0;
      idle_lines();
      wait_tick(nb, nc); wait_tick(nb, nc);
      usb_mode = VEC[i].usb; dp = VEC[i].vdp; dm = VEC[i].vdm; ps2_data = VEC[i].vps2;
      for (int t = 0; t < int'(VEC[i].hold); t++) wait_tick(hb, hc);
      check(hb == int'(VEC[i].n_hold), $sformatf("R3/R4/R5 vec%0d irq during hold", i),
            hb, VEC[i].n_hold);
      check(addr_clear == VEC[i].clr, $sformatf("R6 vec%0d addr_clear held", i),
            addr_clear, VEC[i].clr);
      idle_lines();
      wait_tick(rb, rc);
      check(rb == int'(VEC[i].n_rel), $sformatf("R5 vec%0d irq at release", i),
            rb, VEC[i].n_rel);
      check(!addr_clear, $sformatf("R6 vec%0d addr_clear released", i), addr_clear, 0);
      if (hb + rb > 0)
        check(hc + rc == hb + rb, $sformatf("R9 vec%0d bus and timer same cycle", i),
              hc + rc, hb + rb);
    end

    // R3 glitch between ticks ignored
    usb_mode = 1'b0; idle_lines();
    nb = 0; nc = 0;
    wait_tick(nb, nc);
    repeat (3) @(negedge clk);
    ps2_data = 1'b0;
    repeat (CYC - 6) @(negedge clk);
    ps2_data = 1'b1;
    wait_tick(nb, nc);
    ps2_data = 1'b0;
    wait_tick(nb, nc);
    check(nb == 0 && !addr_clear, "R3 glitch not counted", nb, 0);
    ps2_data = 1'b1;

    // R8 reset mid-event
    usb_mode = 1'b1; dp = 1'b0; dm = 1'b0;
    wait_tick(nb, nc); wait_tick(nb, nc); wait_tick(nb, nc);
    check(addr_clear == 1'b1, "R6 SE0 event active", addr_clear, 1);
    rst_n = 1'b0;
    @(negedge clk);
    check(!addr_clear && !irq_bus, "R8 reset mid-event", addr_clear, 0);
    idle_lines();
    rst_n = 1'b1;
    last = 0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule